// File: doc/BRIEF.md
# Page-Mode Asynchronous DRAM Controller

This block is a clocked sequencer for an asynchronous DRAM whose row and column addresses share one set of address pins. A host presents one word-wide read or write at a time. The controller splits the host address into a row half and a column half. It opens the row with an active-low row strobe and then selects the column with an active-low column strobe. After the access the row is left open, so a following request to the same row needs only one more column strobe pulse and skips the activation. A request to a different row closes the page, waits out the precharge time and opens the new row.

A free-running interval timer marks a refresh as due. The controller then closes any open row and performs a refresh cycle in which the column strobe falls before the row strobe. The DRAM picks the row to refresh from its own counter, so no address is driven. All DRAM timings are parameters counted in whole controller clocks. The defaults suit a 100 MHz clock and a 50 ns part.

Top module: `pagedram_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, `mem_ras_n`, `mem_cas_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `req_done` is 0.
- R2: When `mem_cas_n` falls while `mem_ras_n` is low, at least T_RCD clock cycles have passed since `mem_ras_n` fell.
- R3: Once `mem_ras_n` goes low it stays low for at least T_RAS cycles, for both accesses and refreshes.
- R4: Once `mem_ras_n` goes high it stays high for at least T_RP cycles before it falls again.
- R5: When the row strobe falls for an access, `mem_addr` carries the row field `req_addr[2*MA-1:MA]`. When the column strobe falls, `mem_addr` carries the column field `req_addr[MA-1:0]`.
- R6: A request to the row that is already open does not activate a row again. If requests arrive back to back, successive column strobe falls are max(T_CAS,T_CAC)+1 cycles apart.
- R7: A request to a row other than the open one raises `mem_ras_n` and then activates the new row, so there is exactly one activation per row change.
- R8: Refresh comes due every REF_INT cycles. With the block idle, consecutive refreshes are exactly REF_INT cycles apart. In a refresh, `mem_cas_n` is low when `mem_ras_n` falls, it fell at least one cycle earlier, and `mem_we_n` stays 1.
- R9: A due refresh takes priority over host requests. An unbroken stream of same-row requests lasting longer than REF_INT cycles still sees a refresh performed.
- R10: Each request ends with `req_done` high for exactly one cycle. For a read, `rsp_rdata` then holds the value sampled from `mem_dq_in` max(T_CAS,T_CAC) cycles after the column strobe fell. For a write, `mem_dq_oe` is 1 and `mem_dq_out` equals `req_wdata` whenever `mem_we_n` is 0, and `mem_we_n` is 0 only while `mem_cas_n` is low. The host holds its request fields stable until `req_done` and changes or drops them in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*MA | Word address: row in the upper half, column in the lower half |
| req_wdata | input | DW | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid with `req_done` on reads |
| mem_addr | output | MA | Multiplexed DRAM address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DW | Data driven toward the DRAM |
| mem_dq_oe | output | 1 | Output enable for `mem_dq_out` |
| mem_dq_in | input | DW | Data returned by the DRAM |

## Verification
The bench builds the controller with 4-bit address halves, 8-bit data, T_RCD=2, T_RAS=5, T_RP=3, T_CAS=1, T_CAC=2 and a refresh interval cut to 150 cycles. The short interval makes refreshes land inside page bursts, inside row changes and during a continuous same-row stream, so refresh priority and the forced page close are exercised many times. The 16-row by 16-column space is small enough that random traffic moves between page hits and row misses often, and it lets a bench-side memory model check every read against written data.

// File: rtl/pagedram_ctrl.sv
module pagedram_ctrl #(
  parameter int MA      = 10,
  parameter int DW      = 16,
  parameter int T_RCD   = 2,
  parameter int T_RAS   = 5,
  parameter int T_RP    = 3,
  parameter int T_CAS   = 1,
  parameter int T_CAC   = 2,
  parameter int REF_INT = 780
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [2*MA-1:0] req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            req_done,
  output logic [DW-1:0]   rsp_rdata,
  output logic [MA-1:0]   mem_addr,
  output logic            mem_ras_n,
  output logic            mem_cas_n,
  output logic            mem_we_n,
  output logic [DW-1:0]   mem_dq_out,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_in
);
  localparam int CAS_LOW = (T_CAS > T_CAC) ? T_CAS : T_CAC;
  localparam int CW = $clog2(T_RCD + T_RAS + T_RP + CAS_LOW + 2);
  localparam int RW = (REF_INT > 2) ? $clog2(REF_INT) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RCD, S_CAS, S_PAGE, S_PRE, S_CBR_SETUP, S_CBR_HOLD
  } state_t;

  state_t          state;
  logic [CW-1:0]   cnt, ras_age;
  logic [MA-1:0]   open_row;
  logic [RW-1:0]   ref_cnt;
  logic            ref_pend, cur_wr;

  wire [MA-1:0] req_row    = req_addr[2*MA-1:MA];
  wire [MA-1:0] req_col    = req_addr[MA-1:0];
  wire          tras_met   = ras_age >= CW'(T_RAS);
  wire          want_close = ref_pend || (req_valid && req_row != open_row);
  wire          start_cbr  = (state == S_IDLE) && ref_pend;
  wire          launch     = (state == S_RCD && cnt == CW'(T_RCD)) ||
                             (state == S_PAGE && !want_close && req_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt  <= RW'(REF_INT - 1);
      ref_pend <= 1'b0;
    end else begin
      ref_cnt <= (ref_cnt == '0) ? RW'(REF_INT - 1) : ref_cnt - 1'b1;
      if (ref_cnt == '0)  ref_pend <= 1'b1;
      else if (start_cbr) ref_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      ras_age    <= '0;
      open_row   <= '0;
      cur_wr     <= 1'b0;
      req_done   <= 1'b0;
      rsp_rdata  <= '0;
      mem_addr   <= '0;
      mem_ras_n  <= 1'b1;
      mem_cas_n  <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      req_done <= 1'b0;
      if (!mem_ras_n && !tras_met) ras_age <= ras_age + 1'b1;
      case (state)
        S_IDLE:
          if (ref_pend) begin
            mem_cas_n <= 1'b0;
            state     <= S_CBR_SETUP;
          end else if (req_valid) begin
            mem_ras_n <= 1'b0;
            mem_addr  <= req_row;
            open_row  <= req_row;
            ras_age   <= CW'(1);
            cnt       <= CW'(1);
            state     <= S_RCD;
          end
        S_RCD:
          if (!launch) cnt <= cnt + 1'b1;
        S_CAS:
          if (cnt == CW'(CAS_LOW)) begin
            mem_cas_n <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            if (!cur_wr) rsp_rdata <= mem_dq_in;
            req_done  <= 1'b1;
            state     <= S_PAGE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_PAGE:
          if (want_close && tras_met) begin
            mem_ras_n <= 1'b1;
            cnt       <= CW'(1);
            state     <= S_PRE;
          end
        S_PRE:
          if (int'(cnt) >= T_RP - 1) state <= S_IDLE;
          else cnt <= cnt + 1'b1;
        S_CBR_SETUP: begin
          mem_ras_n <= 1'b0;
          ras_age   <= CW'(1);
          state     <= S_CBR_HOLD;
        end
        S_CBR_HOLD:
          if (tras_met) begin
            mem_ras_n <= 1'b1;
            mem_cas_n <= 1'b1;
            cnt       <= CW'(1);
            state     <= S_PRE;
          end
        default: state <= S_IDLE;
      endcase
      if (launch) begin
        mem_cas_n  <= 1'b0;
        mem_addr   <= req_col;
        mem_we_n   <= !req_write;
        mem_dq_oe  <= req_write;
        mem_dq_out <= req_wdata;
        cur_wr     <= req_write;
        cnt        <= CW'(1);
        state      <= S_CAS;
      end
    end
  end
endmodule

// File: rtl/pagedram_ctrl_chk.sv
module pagedram_ctrl_chk #(
  parameter int T_RCD = 2,
  parameter int T_RAS = 5,
  parameter int T_RP  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_done,
  input logic mem_ras_n,
  input logic mem_cas_n,
  input logic mem_we_n,
  input logic mem_dq_oe
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= 16'(T_RP);
    end else begin
      lo_cnt <= mem_ras_n ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !mem_ras_n ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  a_r2_rcd_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cas_n) && !mem_ras_n) |-> lo_cnt >= 16'(T_RCD));

  a_r3_ras_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ras_n) |-> lo_cnt >= 16'(T_RAS));

  a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> hi_cnt >= 16'(T_RP));

  a_r8_cbr_order: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ras_n) && !mem_cas_n) |-> (mem_we_n && !$past(mem_cas_n)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  a_r10_write_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_cas_n));
endmodule

bind pagedram_ctrl pagedram_ctrl_chk #(.T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_done(req_done), .mem_ras_n(mem_ras_n),
  .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/pagedram_ctrl_tb_top.sv
module pagedram_ctrl_tb_top;
  localparam int MA = 4, DW = 8, T_RCD = 2, T_RAS = 5, T_RP = 3;
  localparam int T_CAS = 1, T_CAC = 2, REF_INT = 150;
  localparam int CAS_LOW = (T_CAS > T_CAC) ? T_CAS : T_CAC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2*MA-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_done, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [MA-1:0] mem_addr;

  pagedram_ctrl #(.MA(MA), .DW(DW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_CAS(T_CAS), .T_CAC(T_CAC), .REF_INT(REF_INT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, ncyc = 0;
  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] shadow [0:255];
  logic [MA-1:0] row_l = '0, col_l = '0;
  assign mem_dq_in = mem[{row_l, col_l}];

  logic prev_ras = 1'b1, prev_cas = 1'b1;
  int t_ras_fall = 0, t_ras_rise = -100, t_cas_fall = -100, cas_gap = 0;
  int act_cnt = 0, ref_evt = 0, last_ref_t = 0, ref_gap = 0;
  logic [2*MA-1:0] cur_addr = '0;
  logic [DW-1:0] cur_wdata = '0;

  function automatic logic [MA-1:0] row_of(input logic [2*MA-1:0] a);
    return a[2*MA-1:MA];
  endfunction
  function automatic logic [MA-1:0] col_of(input logic [2*MA-1:0] a);
    return a[MA-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    ncyc++;
    if (rst_n) begin
      if (prev_ras && !mem_ras_n) begin
        if (!mem_cas_n) begin
          ref_evt++;
          ref_gap = ncyc - last_ref_t;
          last_ref_t = ncyc;
          chk(mem_we_n, "R8 refresh keeps write enable high", mem_we_n, 1);
        end else begin
          act_cnt++;
          row_l = mem_addr;
          chk(mem_addr == row_of(cur_addr), "R5 row on address at activation",
              mem_addr, row_of(cur_addr));
        end
        chk(ncyc - t_ras_rise >= T_RP, "R4 precharge time", ncyc - t_ras_rise, T_RP);
        t_ras_fall = ncyc;
      end
      if (!prev_ras && mem_ras_n) begin
        chk(ncyc - t_ras_fall >= T_RAS, "R3 row active time", ncyc - t_ras_fall, T_RAS);
        t_ras_rise = ncyc;
      end
      if (prev_cas && !mem_cas_n && !mem_ras_n) begin
        col_l = mem_addr;
        chk(mem_addr == col_of(cur_addr), "R5 column on address at column strobe",
            mem_addr, col_of(cur_addr));
        chk(ncyc - t_ras_fall >= T_RCD, "R2 row to column delay", ncyc - t_ras_fall, T_RCD);
        cas_gap = ncyc - t_cas_fall;
        t_cas_fall = ncyc;
        if (!mem_we_n) begin
          chk(mem_dq_oe && mem_dq_out == cur_wdata, "R10 write data driven",
              mem_dq_out, cur_wdata);
          mem[{row_l, mem_addr}] = mem_dq_out;
        end
      end
    end
    prev_ras = mem_ras_n;
    prev_cas = mem_cas_n;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (ncyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", ncyc, 150000);
      finish_run();
    end
  end

  task automatic do_req(input bit wr, input logic [2*MA-1:0] a, input logic [DW-1:0] d);
    int n = 0;
    cur_addr = a; cur_wdata = d;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) shadow[a] = d;
    do begin @(negedge clk); n++; end while (!req_done && n < 500);
    chk(req_done, "R10 completion pulse seen", req_done, 1);
    if (!wr) chk(rsp_rdata == shadow[a], "R10 read data", rsp_rdata, shadow[a]);
    req_valid = 1'b0;
  endtask

  task automatic wait_refreshes(input int target);
    int n = 0;
    while (ref_evt < target && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int a0, r0, c0;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (4) @(negedge clk);
    chk(mem_ras_n && mem_cas_n && mem_we_n && !mem_dq_oe && !req_done,
        "R1 strobes idle in reset", {mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe, req_done}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ras_n && mem_cas_n && mem_we_n && !mem_dq_oe && !req_done,
        "R1 strobes idle after reset", {mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe, req_done}, 5'b11100);

    wait_refreshes(2);
    chk(ref_gap == REF_INT, "R8 idle refresh interval", ref_gap, REF_INT);

    a0 = act_cnt;
    for (int c = 0; c < 4; c++) do_req(1'b1, {4'd3, 4'(c)}, 8'hA0 + 8'(c));
    for (int c = 0; c < 4; c++) do_req(1'b0, {4'd3, 4'(c)}, '0);
    chk(act_cnt - a0 == 1, "R6 page hits need no new activation", act_cnt - a0, 1);
    chk(cas_gap == CAS_LOW + 1, "R6 page cycle spacing", cas_gap, CAS_LOW + 1);
    @(negedge clk);
    chk(!req_done, "R10 completion lasts one cycle", req_done, 0);

    a0 = act_cnt;
    do_req(1'b1, {4'd5, 4'd1}, 8'h5A);
    do_req(1'b0, {4'd3, 4'd2}, '0);
    do_req(1'b0, {4'd5, 4'd1}, '0);
    chk(act_cnt - a0 == 3, "R7 one activation per row change", act_cnt - a0, 3);
    chk(mem_ras_n == 1'b0, "R7 new row left open", mem_ras_n, 0);

    r0 = ref_evt; c0 = ncyc;
    while (ncyc - c0 < 2 * REF_INT) do_req(1'b0, {4'd2, 4'($urandom_range(15))}, '0);
    chk(ref_evt - r0 >= 1, "R9 refresh served during same-row stream", ref_evt - r0, 1);

    r0 = ref_evt; c0 = ncyc;
    for (int i = 0; i < 400; i++) begin
      logic [2*MA-1:0] a;
      a = {4'($urandom_range(3) * 4), 4'($urandom_range(15))};
      if ($urandom_range(1) == 1) a = 8'($urandom_range(255));
      if ($urandom_range(2) == 0) repeat ($urandom_range(3)) @(negedge clk);
      do_req($urandom_range(1) == 1, a, 8'($urandom_range(255)));
    end
    chk(ref_evt - r0 >= (ncyc - c0) / REF_INT - 1, "R8 refresh rate under traffic",
        ref_evt - r0, (ncyc - c0) / REF_INT - 1);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule